// File: doc/BRIEF.md
# Switching-Matrix Host Command Unit

This block is the host-facing command unit of a time/space switching matrix. A host writes bytes over an 8-bit parallel port that has read and write strobes, two chip selects and a data/command select line. It writes operand bytes first and the command byte last. The unit keeps the most recent operand bytes in a short shift stack. When the command byte arrives, it decodes the instruction, builds one access to the switching core's control or output store, and issues that access over a valid/ready request. It waits on `core_ready` for as long as the core holds it off. Results come back to the host in two readable result registers.

Several identical chips can share one host bus. Each chip compares two identity inputs with two strap inputs. The chip whose identity matches its straps performs connect and byte insert. Every other selected chip turns those two commands into a release of the same output channel, so host software never has to send explicit teardowns. A channel-0 extraction mode loads the channel-0 bytes of a masked set of input lines into the first result register. While that mode is running, every other instruction waits.

Request channel rules: `core_valid` rises the cycle after an accepted command. It stays high, with `core_op`, `core_line`, `core_chan` and `core_word` unchanged, until a cycle in which `core_ready` is high. That cycle completes the transfer, and `core_rdata` is sampled in the same cycle.

Top module: `xbar_host_if`

## Requirements
- R1: A write or read counts only when `sel_a` and `sel_b` are both high. An unselected write changes neither the stack nor any register, and an unselected read leaves `rdata_oe` low.
- R2: The chip is in match when `id_a == strap_a` and `id_b == strap_b`. `rdata_oe` is high only for a selected read on a matching chip. During that read, `rdata` shows result register 1 when `is_cmd` = 0 and result register 2 when `is_cmd` = 1. Result register 2 is {5'b0, ch0_active, busy, c8}. Both result registers reset to 0.
- R3: The low 3 bits of the command select the instruction: 1 connect, 2 disconnect, 3 insert, 4 extract, 5 map read, 6 channel-0 mask. For a matching chip, connect with operands (in line, in chan, out line, out chan) writes control word {1'b0, in_line[2:0], in_chan[4:0]} at the out line and channel. A write uses `core_op` = 0.
- R4: Disconnect with operands (out line, out chan) writes word 9'h1FF on a matching chip. A non-matching chip ignores it.
- R5: Insert with operands (hi, lo, out line, out chan) writes word {1'b1, hi[3:0], lo[3:0]} on a matching chip.
- R6: A selected, non-matching chip turns connect and insert into a write of 9'h1FF at the same out line and channel.
- R7: Extract (out line, out chan) issues `core_op` = 2 and loads `core_rdata[7:0]` into result register 1. A non-matching chip ignores it.
- R8: Map read (out line, out chan) issues `core_op` = 1 whether or not the chip matches. It loads `core_rdata[7:0]` into result register 1 and `core_rdata[8]` into c8.
- R9: Codes 0 and 7 are ignored. A command byte written while busy is dropped.
- R10: busy is high from the cycle after command receipt until the cycle after the completing handshake. The request holds steady while `core_ready` is low. With `core_ready` high, `core_valid` is seen the cycle after the command and the transfer completes at the next edge.
- R11: Channel-0 mask (one mask byte) drives `ch0_mask` and sets ch0_active when the mask is non-zero. Each `ch0_valid` loads `ch0_byte` into result register 1. ch0_active clears after as many bytes as the mask has set bits, or at `frame_start`. While ch0_active is set, an accepted command waits with busy set and `core_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a | input | 1 | Chip select A, active high |
| sel_b | input | 1 | Chip select B, active high |
| wr_stb | input | 1 | Host write strobe, one cycle per byte |
| rd_stb | input | 1 | Host read strobe |
| is_cmd | input | 1 | 1 = command byte or result register 2, 0 = data byte or result register 1 |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| rdata_oe | output | 1 | Read data drive enable |
| id_a | input | 2 | Identity input A |
| id_b | input | 2 | Identity input B |
| strap_a | input | 2 | Strap A |
| strap_b | input | 2 | Strap B |
| frame_start | input | 1 | Frame start pulse |
| core_valid | output | 1 | Core request valid |
| core_ready | input | 1 | Core request accepted |
| core_op | output | 2 | 0 write control word, 1 read control word, 2 read output byte |
| core_line | output | 3 | Output line of the request |
| core_chan | output | 5 | Output channel of the request |
| core_word | output | 9 | Control word for writes |
| core_rdata | input | 9 | Read data returned with the handshake |
| ch0_mask | output | 8 | Channel-0 extraction line mask |
| ch0_valid | input | 1 | A channel-0 byte is presented |
| ch0_byte | input | 8 | Channel-0 byte |

## Verification
Two events can meet in one cycle: a command byte being written and the `frame_start` that ends a channel-0 extraction. The bench writes the extract command in the same cycle that it pulses `frame_start`. Because ch0_active is still set at that edge, the command must wait one cycle before the request is issued. The bench judges this by the single completed transfer and by result register 2 showing busy and ch0_active both cleared afterwards. It also issues a second command while a request is being held off, and checks that only the first one reaches the core.

// File: rtl/hcif_pkg.sv
package hcif_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_CONN = 3'd1, OP_DISC = 3'd2, OP_INS  = 3'd3,
    OP_EXT  = 3'd4, OP_MAP  = 3'd5, OP_MASK = 3'd6, OP_RSVD = 3'd7
  } host_op_e;

  typedef enum logic [1:0] {
    CORE_WR = 2'd0, CORE_RDCM = 2'd1, CORE_RDOUT = 2'd2, CORE_NA = 2'd3
  } core_op_e;

  typedef struct packed {
    logic       valid;
    logic       is_mask;
    core_op_e   op;
    logic [7:0] line_b;
    logic [7:0] chan_b;
    logic [8:0] word;
  } issue_t;

  localparam logic [8:0] RELEASE_WORD = 9'h1FF;
endpackage

// File: rtl/hcif_stack.sv
module hcif_stack #(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [7:0]            din,
  output logic [DEPTH-1:0][7:0] stk
);
  always_ff @(posedge clk) begin
    if (!rst_n)    stk[0] <= '0;
    else if (push) stk[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rst_n)    stk[i] <= '0;
      else if (push) stk[i] <= stk[i-1];
    end
  end
endmodule

// File: rtl/hcif_decode.sv
module hcif_decode
  import hcif_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int CHAN_W = 5
) (
  input  logic [7:0]      cmd,
  input  logic [3:0][7:0] stk,
  input  logic            match,
  output issue_t          iss
);
  localparam int SEL_W = LINE_W + CHAN_W;

  logic [SEL_W-1:0] in_sel;
  logic [7:0]       ins_byte;

  assign in_sel   = {stk[3][LINE_W-1:0], stk[2][CHAN_W-1:0]};
  assign ins_byte = {stk[3][3:0], stk[2][3:0]};

  always_comb begin
    iss        = '0;
    iss.op     = CORE_WR;
    iss.line_b = stk[1];
    iss.chan_b = stk[0];
    case (cmd[2:0])
      OP_CONN: begin
        iss.valid = 1'b1;
        iss.word  = match ? 9'(in_sel) : RELEASE_WORD;
      end
      OP_DISC: begin
        iss.valid = match;
        iss.word  = RELEASE_WORD;
      end
      OP_INS: begin
        iss.valid = 1'b1;
        iss.word  = match ? {1'b1, ins_byte} : RELEASE_WORD;
      end
      OP_EXT: begin
        iss.valid = match;
        iss.op    = CORE_RDOUT;
      end
      OP_MAP: begin
        iss.valid = 1'b1;
        iss.op    = CORE_RDCM;
      end
      OP_MASK: begin
        iss.valid   = match;
        iss.is_mask = 1'b1;
        iss.word    = {1'b0, stk[0]};
      end
      default: iss = '0;
    endcase
  end
endmodule

// File: rtl/hcif_exec.sv
module hcif_exec
  import hcif_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int CHAN_W = 5,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  issue_t            iss,
  input  logic              frame_start,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [1:0]        core_op,
  output logic [LINE_W-1:0] core_line,
  output logic [CHAN_W-1:0] core_chan,
  output logic [8:0]        core_word,
  input  logic [8:0]        core_rdata,
  input  logic              ch0_valid,
  input  logic [7:0]        ch0_byte,
  output logic [MASK_W-1:0] ch0_mask,
  output logic [7:0]        or1,
  output logic [7:0]        or2
);
  localparam int REM_W = $clog2(MASK_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ} st_e;
  st_e st;

  core_op_e    op_q;
  logic        c8, ch0_act;
  logic [REM_W-1:0] rem, popc;
  logic        accept;

  always_comb begin
    popc = '0;
    for (int i = 0; i < MASK_W; i++) popc = popc + REM_W'(iss.word[i]);
  end

  assign accept     = cmd_stb && iss.valid && (st == S_IDLE);
  assign core_valid = (st == S_REQ);
  assign core_op    = op_q;
  assign or2        = {5'b0, ch0_act, (st != S_IDLE), c8};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= CORE_WR; core_line <= '0; core_chan <= '0;
      core_word <= '0; or1 <= '0; c8 <= 1'b0; ch0_act <= 1'b0;
      rem <= '0; ch0_mask <= '0;
    end else begin
      if (ch0_act) begin
        if (ch0_valid) begin
          or1 <= ch0_byte;
          rem <= rem - 1'b1;
        end
        if (frame_start || (ch0_valid && rem == REM_W'(1))) ch0_act <= 1'b0;
      end
      case (st)
        S_IDLE: if (accept) begin
          if (iss.is_mask) begin
            ch0_mask <= iss.word[MASK_W-1:0];
            rem      <= popc;
            ch0_act  <= (popc != '0);
          end else begin
            op_q      <= iss.op;
            core_line <= iss.line_b[LINE_W-1:0];
            core_chan <= iss.chan_b[CHAN_W-1:0];
            core_word <= iss.word;
            st        <= ch0_act ? S_WAIT : S_REQ;
          end
        end
        S_WAIT: if (!ch0_act) st <= S_REQ;
        S_REQ: if (core_ready) begin
          case (op_q)
            CORE_RDCM:  begin or1 <= core_rdata[7:0]; c8 <= core_rdata[8]; end
            CORE_RDOUT: or1 <= core_rdata[7:0];
            default: ;
          endcase
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: a held-off request keeps its fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && !core_ready |=> core_valid && $stable(core_word) &&
    $stable(core_line) && $stable(core_chan) && $stable(core_op));

  // R10: a request is only outstanding while busy is reported
  a_r10_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> or2[1]);

  // R11: no core access while channel-0 extraction runs
  a_r11_ch0_excl: assert property (@(posedge clk) disable iff (!rst_n)
    or2[2] |-> !core_valid);
endmodule

// File: rtl/xbar_host_if.sv
module xbar_host_if
  import hcif_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int CHAN_W = 5,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              is_cmd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  input  logic [ID_W-1:0]   id_a,
  input  logic [ID_W-1:0]   id_b,
  input  logic [ID_W-1:0]   strap_a,
  input  logic [ID_W-1:0]   strap_b,
  input  logic              frame_start,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [1:0]        core_op,
  output logic [LINE_W-1:0] core_line,
  output logic [CHAN_W-1:0] core_chan,
  output logic [8:0]        core_word,
  input  logic [8:0]        core_rdata,
  output logic [7:0]        ch0_mask,
  input  logic              ch0_valid,
  input  logic [7:0]        ch0_byte
);
  localparam int STACK_D = 4;

  logic                    acc, match, push, cmd_stb;
  logic [STACK_D-1:0][7:0] stk;
  logic [7:0]              or1, or2;
  issue_t                  iss;

  assign acc     = sel_a && sel_b;
  assign match   = (id_a == strap_a) && (id_b == strap_b);
  assign push    = acc && wr_stb && !is_cmd;
  assign cmd_stb = acc && wr_stb && is_cmd;

  hcif_stack #(.DEPTH(STACK_D)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wdata), .stk(stk));

  hcif_decode #(.LINE_W(LINE_W), .CHAN_W(CHAN_W)) u_dec (
    .cmd(wdata), .stk(stk), .match(match), .iss(iss));

  hcif_exec #(.LINE_W(LINE_W), .CHAN_W(CHAN_W), .MASK_W(8)) u_exec (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .iss(iss),
    .frame_start(frame_start), .core_valid(core_valid),
    .core_ready(core_ready), .core_op(core_op), .core_line(core_line),
    .core_chan(core_chan), .core_word(core_word), .core_rdata(core_rdata),
    .ch0_valid(ch0_valid), .ch0_byte(ch0_byte), .ch0_mask(ch0_mask),
    .or1(or1), .or2(or2));

  assign rdata_oe = acc && rd_stb && match;
  assign rdata    = rdata_oe ? (is_cmd ? or2 : or1) : 8'h00;

  // R2: only a matching chip may drive the read bus
  a_r2_oe_match: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (id_a == strap_a) && (id_b == strap_b) && sel_a && sel_b);
endmodule

// File: tb/sim_xbar_host_if.sv
`timescale 1ns/1ps
module sim_xbar_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b1, sel_b = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0, is_cmd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe;
  logic [1:0] id_a = 2'd1, id_b = 2'd2, strap_a = 2'd1, strap_b = 2'd2;
  logic frame_start = 1'b0, core_valid, core_ready = 1'b1;
  logic [1:0] core_op;
  logic [2:0] core_line;
  logic [4:0] core_chan;
  logic [8:0] core_word, core_rdata = '0;
  logic [7:0] ch0_mask;
  logic ch0_valid = 1'b0;
  logic [7:0] ch0_byte = '0;

  int checks = 0, fails = 0, log_cnt = 0;
  logic [1:0] log_op;
  logic [2:0] log_line;
  logic [4:0] log_chan;
  logic [8:0] log_word;

  always #2.5 clk = ~clk;

  xbar_host_if u0 (.*);

  always @(posedge clk) if (rst_n && core_valid && core_ready) begin
    log_op <= core_op; log_line <= core_line; log_chan <= core_chan;
    log_word <= core_word; log_cnt <= log_cnt + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, logic c);
    wdata = d; is_cmd = c; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; is_cmd = 1'b0;
  endtask

  task automatic rd(logic c, output logic [7:0] d, output logic oe);
    is_cmd = c; rd_stb = 1'b1;
    #0.5;
    d = rdata; oe = rdata_oe;
    rd_stb = 1'b0; is_cmd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    check("R2 reset valid", core_valid, 0);
    check("R11 reset mask", ch0_mask, 0);
    rd(1'b0, d, oe); check("R2 reset or1", {oe, d}, 9'h100);
    rd(1'b1, d, oe); check("R2 reset or2", {oe, d}, 9'h100);
  endtask

  task automatic t_select;
    logic [7:0] d; logic oe; int n;
    n = log_cnt;
    sel_b = 1'b0;
    wr(8'h02, 0); wr(8'h11, 0); wr(8'h05, 0); wr(8'h1A, 0); wr(8'h01, 1);
    idle(4);
    check("R1 unselected write", log_cnt, n);
    rd(1'b0, d, oe); check("R1 unselected read oe", oe, 0);
    sel_b = 1'b1;
  endtask

  task automatic t_connect;
    int n = log_cnt;
    wr(8'h02, 0); wr(8'h11, 0); wr(8'h05, 0); wr(8'h1A, 0); wr(8'h01, 1);
    check("R10 valid next cycle", core_valid, 1);
    idle(2);
    check("R3 connect count", log_cnt, n + 1);
    check("R3 connect fields", {log_op, log_line, log_chan, log_word},
          {2'd0, 3'd5, 5'h1A, 9'h051});
  endtask

  task automatic t_map;
    logic [7:0] d; logic oe;
    core_rdata = 9'h151;
    wr(8'h05, 0); wr(8'h1A, 0); wr(8'h05, 1); idle(2);
    check("R8 map op", {log_op, log_line, log_chan}, {2'd1, 3'd5, 5'h1A});
    rd(1'b0, d, oe); check("R8 map or1", {oe, d}, 9'h151);
    rd(1'b1, d, oe); check("R8 map or2", {oe, d}, 9'h101);
  endtask

  task automatic t_insert;
    wr(8'h0A, 0); wr(8'h0B, 0); wr(8'h03, 0); wr(8'h04, 0); wr(8'h03, 1); idle(2);
    check("R5 insert", {log_op, log_line, log_chan, log_word},
          {2'd0, 3'd3, 5'd4, 9'h1AB});
  endtask

  task automatic t_extract;
    logic [7:0] d; logic oe;
    core_rdata = 9'h0C7;
    wr(8'h03, 0); wr(8'h04, 0); wr(8'h04, 1); idle(2);
    check("R7 extract op", {log_op, log_line, log_chan}, {2'd2, 3'd3, 5'd4});
    rd(1'b0, d, oe); check("R7 extract or1", d, 8'hC7);
  endtask

  task automatic t_disc;
    wr(8'h06, 0); wr(8'h1F, 0); wr(8'h02, 1); idle(2);
    check("R4 disconnect", {log_op, log_line, log_chan, log_word},
          {2'd0, 3'd6, 5'h1F, 9'h1FF});
  endtask

  task automatic t_nomatch;
    logic [7:0] d; logic oe; int n;
    id_a = 2'd0;
    wr(8'h01, 0); wr(8'h02, 0); wr(8'h07, 0); wr(8'h03, 0); wr(8'h01, 1); idle(2);
    check("R6 nomatch connect", {log_op, log_line, log_chan, log_word},
          {2'd0, 3'd7, 5'd3, 9'h1FF});
    wr(8'h0A, 0); wr(8'h0B, 0); wr(8'h02, 0); wr(8'h09, 0); wr(8'h03, 1); idle(2);
    check("R6 nomatch insert", {log_line, log_chan, log_word}, {3'd2, 5'd9, 9'h1FF});
    n = log_cnt;
    wr(8'h02, 0); wr(8'h09, 0); wr(8'h02, 1);
    wr(8'h04, 1); wr(8'h0F, 0); wr(8'h06, 1); idle(3);
    check("R4 R7 nomatch ignored", log_cnt, n);
    check("R11 nomatch mask ignored", ch0_mask, 0);
    rd(1'b0, d, oe); check("R2 nomatch no drive", oe, 0);
    core_rdata = 9'h033;
    wr(8'h02, 0); wr(8'h09, 0); wr(8'h05, 1); idle(2);
    check("R8 nomatch map", {log_cnt, log_op}, {n + 1, 2'd1});
    id_a = 2'd1;
    rd(1'b0, d, oe); check("R8 nomatch map or1", {oe, d}, 9'h133);
  endtask

  task automatic t_undef_busy;
    logic [7:0] d; logic oe; int n;
    n = log_cnt;
    wr(8'h00, 1); wr(8'h07, 1); idle(3);
    check("R9 undefined codes", {log_cnt, 8'(ch0_mask)}, {n, 8'h00});
    core_ready = 1'b0;
    wr(8'h01, 0); wr(8'h02, 0); wr(8'h04, 0); wr(8'h05, 0); wr(8'h01, 1);
    rd(1'b1, d, oe); check("R10 busy set", d[1], 1);
    idle(3);
    check("R10 held valid", {core_valid, core_line, core_chan, core_word},
          {1'b1, 3'd4, 5'd5, 9'h022});
    wr(8'h06, 0); wr(8'h07, 0); wr(8'h02, 1);
    core_ready = 1'b1; idle(4);
    check("R9 busy drop count", log_cnt, n + 1);
    check("R9 busy drop word", log_word, 9'h022);
    rd(1'b1, d, oe); check("R10 busy clear", d[1], 0);
  endtask

  task automatic t_ch0;
    logic [7:0] d; logic oe; int n;
    wr(8'h05, 0); wr(8'h06, 1);
    check("R11 mask port", ch0_mask, 8'h05);
    rd(1'b1, d, oe); check("R11 active flag", d[2:1], 2'b10);
    n = log_cnt; core_rdata = 9'h07E;
    wr(8'h03, 0); wr(8'h04, 0); wr(8'h04, 1); idle(3);
    check("R11 waits", {core_valid, log_cnt}, {1'b0, n});
    rd(1'b1, d, oe); check("R11 busy waiting", d[2:1], 2'b11);
    ch0_byte = 8'hA5; ch0_valid = 1'b1; @(negedge clk); ch0_valid = 1'b0;
    rd(1'b0, d, oe); check("R11 ch0 byte", d, 8'hA5);
    ch0_byte = 8'h3C; ch0_valid = 1'b1; @(negedge clk); ch0_valid = 1'b0;
    idle(3);
    check("R11 released", log_cnt, n + 1);
    rd(1'b0, d, oe); check("R11 or1 after", d, 8'h7E);
    rd(1'b1, d, oe); check("R11 flags clear", d[2:1], 2'b00);
  endtask

  task automatic t_frame;
    logic [7:0] d; logic oe; int n;
    wr(8'h01, 0); wr(8'h06, 1);
    n = log_cnt; core_rdata = 9'h0D2;
    wr(8'h01, 0); wr(8'h02, 0);
    frame_start = 1'b1; wr(8'h04, 1); frame_start = 1'b0;
    check("R11 same-cycle wait", core_valid, 0);
    idle(3);
    check("R11 frame release", log_cnt, n + 1);
    rd(1'b0, d, oe); check("R11 frame or1", d, 8'hD2);
    rd(1'b1, d, oe); check("R11 frame flags", d[2:1], 2'b00);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset; t_select; t_connect; t_map; t_insert; t_extract; t_disc;
    t_nomatch; t_undef_busy; t_ch0; t_frame;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule